// File: doc/BRIEF.md
# Multiframe Clock and Reference Pulse Generator

This block runs entirely in the link clock domain of a high-speed serial converter link. It keeps a local multiframe counter and raises a one-cycle strobe at each multiframe boundary. A second counter produces a periodic reference pulse. One pulse appears per multiframe, and the pulse is meant to be fanned out to the converter and to the receive link logic.

An external reference input is watched for rising edges. An accepted edge restarts the local multiframe counter, so the boundary realigns to that edge. A programmable offset then delays the boundary by a chosen number of link clocks. This is how the receive latency is tuned.

Two capture policies are available. The default acts only on the first edge after reset and ignores all later edges. The alternative acts on every edge. A status output shows whether the block is still waiting for that first edge.

Top module: `lmfc_sysref_gen`

## Requirements
- R1: `sysref_out` is high for exactly one link clock once every L link clocks, where L is the effective multiframe length. It is high in the cycle in which reset is released.
- R2: The effective multiframe length L equals `mf_len` when `mf_len` is 2 or more. A `mf_len` value of 0 or 1 is treated as L = 2.
- R3: If `sysref_in` is low at one rising clock edge and high at the next (edge k), and the edge is accepted with a zero offset, then `lmfc_strobe` is high in the cycle after edge k+1. From then on it is high every L cycles and low otherwise.
- R4: With offset value O, the boundary of R3 comes (O mod L) cycles later. Offset values of L or more therefore wrap.
- R5: When `cap_every` is 0, only the first rising edge after reset realigns the counter. Later edges leave the boundary phase unchanged.
- R6: When `cap_every` is 1, every rising edge of `sysref_in` realigns the counter as in R3 and R4.
- R7: `armed` is 1 after reset. It drops to 0 at edge k+1 for the first detected rising edge and then stays 0 until the next reset, whatever the capture policy.
- R8: While reset is asserted, and in the cycle it is released, both counters are at zero. `sysref_out`, `lmfc_strobe` and `armed` all read 1.
- R9: Holding `sysref_in` high for several cycles counts as a single edge. The realignment is anchored to the first high sample only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mf_len | input | CNT_W | Multiframe length in link clocks (values below 2 act as 2) |
| cap_every | input | 1 | 0: capture first edge only, 1: capture every edge |
| lmfc_ofs | input | CNT_W | Boundary delay after capture, in link clocks, taken modulo the length |
| sysref_in | input | 1 | External reference input |
| sysref_out | output | 1 | Generated periodic reference pulse |
| lmfc_strobe | output | 1 | Local multiframe boundary strobe |
| armed | output | 1 | 1 while no reference edge has been detected since reset |

## Verification
The bench builds the block with a 5-bit counter width and a single input register. This keeps every length from 0 to 9 and every offset up to two past the length cheap enough to sweep completely, under both capture policies. Each case checks the generated pulse train from reset release and the boundary phase after a first capture. It then checks the phase after a second edge that is deliberately placed out of phase. That second edge separates the ignore policy from the recapture policy and exercises offsets that wrap. Input pulse widths of one to three cycles are mixed in, so a level held high is shown to act as one edge.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;
   typedef enum logic {
      CAP_FIRST = 1'b0,
      CAP_EVERY = 1'b1
   } cap_mode_e;
endpackage

// File: rtl/lmfc_edge_det.sv
module lmfc_edge_det #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 1) begin : g_bad_stages
      $error("lmfc_edge_det: STAGES must be at least 1");
   end

   logic [STAGES-1:0] stg;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= 1'b0;
            else        stg[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= 1'b0;
            else        stg[i] <= stg[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b0;
      else        prev <= stg[STAGES-1];

   assign rise = stg[STAGES-1] & ~prev;

   // R9: a detected edge is never followed directly by another one
   p_single_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/lmfc_wrap_ctr.sv
module lmfc_wrap_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] len_eff,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         zero
);
   localparam logic [W-1:0] ONE = W'(1);

   logic last;
   assign last = (cnt >= len_eff - ONE);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (last) cnt <= '0;
      else           cnt <= cnt + ONE;

   assign zero = (cnt == '0);

   // R1: a boundary lasts one cycle unless a reload forces a new one
   p_one_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> !zero);
   // R1: the final count of a period is followed by a boundary
   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == len_eff - ONE && !load) |=> zero);
endmodule

// File: rtl/lmfc_cap_ctrl.sv
module lmfc_cap_ctrl
   import lmfc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rise,
   input  cap_mode_e mode,
   output logic      accept,
   output logic      armed
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    armed <= 1'b1;
      else if (rise) armed <= 1'b0;

   assign accept = rise & ((mode == CAP_EVERY) | armed);

   // R7: once disarmed, stays disarmed until reset
   p_stay_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !armed);
   // R7: disarming is always caused by a detected edge
   p_fall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(armed) |-> $past(rise));
endmodule

// File: rtl/lmfc_sysref_gen.sv
module lmfc_sysref_gen
   import lmfc_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] mf_len,
   input  logic             cap_every,
   input  logic [CNT_W-1:0] lmfc_ofs,
   input  logic             sysref_in,
   output logic             sysref_out,
   output logic             lmfc_strobe,
   output logic             armed
);
   localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

   if (CNT_W < 2) begin : g_bad_width
      $error("lmfc_sysref_gen: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] len_eff, ofs_mod, load_val, gen_cnt, lmfc_cnt;
   logic             rise, accept;
   cap_mode_e        mode;

   assign len_eff  = (mf_len < MIN_LEN) ? MIN_LEN : mf_len;
   assign ofs_mod  = lmfc_ofs % len_eff;
   assign load_val = (ofs_mod == '0) ? '0 : (len_eff - ofs_mod);
   assign mode     = cap_every ? CAP_EVERY : CAP_FIRST;

   lmfc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(sysref_in), .rise(rise));

   lmfc_cap_ctrl u_cap (
      .clk(clk), .rst_n(rst_n), .rise(rise), .mode(mode),
      .accept(accept), .armed(armed));

   lmfc_wrap_ctr #(.W(CNT_W)) u_gen (
      .clk(clk), .rst_n(rst_n), .len_eff(len_eff), .load(1'b0),
      .load_val('0), .cnt(gen_cnt), .zero(sysref_out));

   lmfc_wrap_ctr #(.W(CNT_W)) u_lmfc (
      .clk(clk), .rst_n(rst_n), .len_eff(len_eff), .load(accept),
      .load_val(load_val), .cnt(lmfc_cnt), .zero(lmfc_strobe));

   // R3: an accepted edge with zero offset yields a boundary next cycle
   p_realign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ofs_mod == '0) |=> lmfc_strobe);
   // R4: a nonzero offset postpones the boundary
   p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ofs_mod != '0) |=> !lmfc_strobe);
   // R5: in first-only mode nothing is accepted once disarmed
   p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_every && !armed) |-> !accept);
   // R6: in every-edge mode each detected edge is accepted
   p_every_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_every && rise) |-> accept);
   // R4: reduced offset always lies inside the multiframe
   p_ofs_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_mod < len_eff);
endmodule

// File: tb/sim_lmfc_sysref_gen.sv
`timescale 1ns/1ps
module sim_lmfc_sysref_gen;
   localparam int W = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] mf_len = '0;
   logic         cap_every = 1'b0;
   logic [W-1:0] lmfc_ofs = '0;
   logic         sysref_in = 1'b0;
   logic         sysref_out, lmfc_strobe, armed;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   lmfc_sysref_gen #(.CNT_W(W), .SYNC_STAGES(1)) u0 (
      .clk(clk), .rst_n(rst_n), .mf_len(mf_len), .cap_every(cap_every),
      .lmfc_ofs(lmfc_ofs), .sysref_in(sysref_in), .sysref_out(sysref_out),
      .lmfc_strobe(lmfc_strobe), .armed(armed));

   task automatic tick();
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic chk(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b cyc=%0d", req, act, exp, cyc);
      end
   endtask

   function automatic bit on_phase(int c, int anchor, int omod, int len);
      int d;
      d = c - anchor - omod;
      return (((d % len) + len) % len) == 0;
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog all R actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      for (int mode = 0; mode < 2; mode++) begin
         for (int len = 0; len < 10; len++) begin
            int eff;
            eff = (len < 2) ? 2 : len;
            for (int ofs = 0; ofs <= eff + 2; ofs++) begin
               int omod, anchor, rel, w, na;
               omod = ofs % eff;
               w = 1 + (ofs % 3);
               rst_n = 1'b0;
               mf_len = W'(len);
               lmfc_ofs = W'(ofs);
               cap_every = mode[0];
               sysref_in = 1'b0;
               tick();
               // R8: reset state
               chk("R8 sysref_out in reset", sysref_out, 1'b1);
               chk("R8 lmfc_strobe in reset", lmfc_strobe, 1'b1);
               chk("R8 armed in reset", armed, 1'b1);
               rst_n = 1'b1;
               rel = cyc;
               // R1/R2: generated pulse train from release
               for (int m = 0; m <= 2 * eff + 1; m++) begin
                  chk("R1 R2 sysref_out period", sysref_out,
                      ((cyc - rel) % eff) == 0);
                  tick();
               end
               chk("R7 armed before edge", armed, 1'b1);
               // first capture, held high for w cycles (R9)
               sysref_in = 1'b1;
               tick();
               anchor = cyc + 1;
               chk("R7 armed not yet cleared", armed, 1'b1);
               for (int m = 0; m <= 2 * eff + 2; m++) begin
                  if (m >= w - 1) sysref_in = 1'b0;
                  tick();
                  if (m == 0) chk("R7 armed cleared", armed, 1'b0);
                  chk("R3 R4 R9 boundary after capture", lmfc_strobe,
                      on_phase(cyc, anchor, omod, eff));
               end
               // second edge, out of phase with the first
               if (((cyc + 2 - anchor) % eff) == 0) tick();
               sysref_in = 1'b1;
               tick();
               sysref_in = 1'b0;
               na = cyc + 1;
               if (mode == 1) anchor = na;
               for (int m = 0; m <= 2 * eff + 1; m++) begin
                  tick();
                  if (mode == 1)
                     chk("R6 realign on later edge", lmfc_strobe,
                         on_phase(cyc, anchor, omod, eff));
                  else
                     chk("R5 later edge ignored", lmfc_strobe,
                         on_phase(cyc, anchor, omod, eff));
               end
               chk("R7 armed stays low", armed, 1'b0);
            end
         end
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule